// File: doc/BRIEF.md
# Serial Montgomery Multiplier with Quotient Capture

This block multiplies two residues in Montgomery form. Given operands held in its registers u and v and an odd modulus p loaded beforehand, it computes u·v·2^-W mod p. W is the operand width: 1024 by default, smaller for simulation. It scans one bit of u per step. A single adder with carry-in feeds a shifter that can pass its input, move it left by one or move it right by one. Every step uses that one datapath.

The result replaces the contents of u. A following multiplication can therefore use it without any reload, which is how exponentiation ladders are chained. A square mode uses u as both factors. During reduction the block also records the parity decision of every step. These bits form the Montgomery quotient q, which is kept in a register of its own and presented on a port. Software can then combine partial products into wider ones.

Operands are written through one shared data bus with three write strobes. A one-cycle start pulse begins an operation. Completion is marked by a one-cycle done pulse.

Top module: `mont_serial_mul`

## Requirements
- R1: After done, u_out holds u·v·2^-W mod p, and this value is strictly less than p. The inputs are the values of u, v and p when start was accepted, p must be odd, and u and v must be below p. A zero operand gives zero.
- R2: If square is 1 in the cycle start is accepted, the block computes u·u·2^-W mod p and ignores v.
- R3: After done, q_out holds a value q below 2^W with u·v + q·p = t·2^W, where t equals either the result or the result plus p. q_out does not change while the block is idle.
- R4: busy rises on the clock edge that accepts start and stays high for exactly 2W+1 cycles. done is high for exactly one cycle, the cycle in which busy has just fallen.
- R5: A start pulse while busy is high is ignored. The running operation's latency and result are unchanged.
- R6: Writes to u, v or p while busy is high are ignored. u_out stays stable while busy, and the next operation sees the old v and p.
- R7: During and after reset, busy, done, u_out and q_out are all 0.
- R8: The result left in u is the u operand of the next operation when u is not rewritten. This allows back-to-back chained products.
- R9: When the pre-correction value t is at least p, p is subtracted once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a product |
| square | input | 1 | Use u as both factors (sampled with start) |
| u_we | input | 1 | Write wdata into u (idle only) |
| v_we | input | 1 | Write wdata into v (idle only) |
| p_we | input | 1 | Write wdata into the modulus p (idle only) |
| wdata | input | W | Operand write data |
| u_out | output | W | Contents of u (result after done) |
| q_out | output | W | Montgomery quotient of the last product |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is host traffic that arrives in the middle of a run. This covers a second start and writes to all three operand registers while the bit loop is active. To reach it, the driver counts cycles after the accepted start. At fixed offsets inside the loop it raises start and each write strobe in turn, carrying data that would corrupt the result. It then checks that the latency, the result and the next chained product are unaffected. The final subtraction taken versus skipped is recovered at the ports from the captured quotient, and the bench requires that both outcomes occur.

// File: rtl/mm_pkg.sv
package mm_pkg;
   typedef enum logic [1:0] {SH_PASS, SH_RIGHT, SH_LEFT} shift_e;
   typedef enum logic [1:0] {XS_ZERO, XS_ONE, XS_ACC} xsel_e;
   typedef enum logic [2:0] {YS_ZERO, YS_V, YS_U, YS_P, YS_NOTP} ysel_e;
   typedef enum logic [1:0] {ST_IDLE, ST_ADD, ST_RED, ST_FIX} state_e;
endpackage

// File: rtl/mm_adder.sv
module mm_adder #(
   parameter int D     = 1026,
   parameter bit SPLIT = 1'b1
) (
   input  logic [D-1:0] x,
   input  logic [D-1:0] y,
   input  logic         cin,
   output logic [D-1:0] sum,
   output logic         cout
);
   generate
      if (SPLIT) begin : g_split
         localparam int LO = D / 2;
         localparam int HI = D - LO;
         logic [LO-1:0] s_lo;
         logic [HI-1:0] s_hi;
         logic          c_lo;
         assign {c_lo, s_lo} = {1'b0, x[LO-1:0]} + {1'b0, y[LO-1:0]} + (LO+1)'(cin);
         assign {cout, s_hi} = {1'b0, x[D-1:LO]} + {1'b0, y[D-1:LO]} + (HI+1)'(c_lo);
         assign sum = {s_hi, s_lo};
      end else begin : g_flat
         assign {cout, sum} = {1'b0, x} + {1'b0, y} + (D+1)'(cin);
      end
   endgenerate
endmodule

// File: rtl/mm_shifter.sv
module mm_shifter
   import mm_pkg::*;
#(
   parameter int D = 1026
) (
   input  shift_e       mode,
   input  logic [D-1:0] din,
   output logic [D-1:0] dout
);
   always_comb begin
      case (mode)
         SH_RIGHT: dout = {1'b0, din[D-1:1]};
         SH_LEFT:  dout = {din[D-2:0], 1'b0};
         default:  dout = din;
      endcase
   end
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
   import mm_pkg::*;
#(
   parameter int W = 1024,
   localparam int IW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          square,
   input  logic          u_bit,
   input  logic          acc_lsb,
   output logic [IW-1:0] idx,
   output xsel_e         x_sel,
   output ysel_e         y_sel,
   output shift_e        sh_mode,
   output logic          cin,
   output logic          acc_we,
   output logic          clr,
   output logic          q_shift,
   output logic          res_we,
   output logic          busy,
   output logic          done
);
   localparam logic [IW-1:0] LAST = IW'(W - 1);

   state_e st;
   logic   sq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         idx  <= '0;
         sq   <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= (st == ST_FIX);
         case (st)
            ST_IDLE: if (start) begin
               st  <= ST_ADD;
               idx <= '0;
               sq  <= square;
            end
            ST_ADD: st <= ST_RED;
            ST_RED: begin
               if (idx == LAST) st <= ST_FIX;
               else begin
                  idx <= idx + 1'b1;
                  st  <= ST_ADD;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      x_sel   = XS_ACC;
      y_sel   = YS_ZERO;
      sh_mode = SH_PASS;
      cin     = 1'b0;
      acc_we  = 1'b0;
      clr     = 1'b0;
      q_shift = 1'b0;
      res_we  = 1'b0;
      case (st)
         ST_IDLE: clr = start;
         ST_ADD: begin
            y_sel  = u_bit ? (sq ? YS_U : YS_V) : YS_ZERO;
            acc_we = 1'b1;
         end
         ST_RED: begin
            y_sel   = acc_lsb ? YS_P : YS_ZERO;
            sh_mode = SH_RIGHT;
            acc_we  = 1'b1;
            q_shift = 1'b1;
         end
         default: begin
            y_sel  = YS_NOTP;
            cin    = 1'b1;
            res_we = 1'b1;
         end
      endcase
   end

   assign busy = (st != ST_IDLE);
endmodule

// File: rtl/mont_serial_mul.sv
module mont_serial_mul
   import mm_pkg::*;
#(
   parameter int W     = 1024,
   parameter bit SPLIT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         square,
   input  logic         u_we,
   input  logic         v_we,
   input  logic         p_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] u_out,
   output logic [W-1:0] q_out,
   output logic         busy,
   output logic         done
);
   localparam int D  = W + 2;
   localparam int IW = $clog2(W);

   if (W < 4) begin : g_bad_width
      $error("mont_serial_mul: W must be at least 4");
   end

   logic [W-1:0]  u_q, v_q, p_q, q_q;
   logic [D-1:0]  acc_q, x_op, y_op, sum, shd;
   logic          cout;
   logic [IW-1:0] idx;
   xsel_e         x_sel;
   ysel_e         y_sel;
   shift_e        sh_mode;
   logic          cin, acc_we, clr, q_shift, res_we;

   mm_ctrl #(.W(W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .square(square),
      .u_bit(u_q[idx]), .acc_lsb(acc_q[0]), .idx(idx),
      .x_sel(x_sel), .y_sel(y_sel), .sh_mode(sh_mode), .cin(cin),
      .acc_we(acc_we), .clr(clr), .q_shift(q_shift), .res_we(res_we),
      .busy(busy), .done(done)
   );

   always_comb begin
      case (x_sel)
         XS_ONE:  x_op = D'(1);
         XS_ACC:  x_op = acc_q;
         default: x_op = '0;
      endcase
      case (y_sel)
         YS_V:    y_op = {2'b00, v_q};
         YS_U:    y_op = {2'b00, u_q};
         YS_P:    y_op = {2'b00, p_q};
         YS_NOTP: y_op = ~{2'b00, p_q};
         default: y_op = '0;
      endcase
   end

   mm_adder #(.D(D), .SPLIT(SPLIT)) u_add (
      .x(x_op), .y(y_op), .cin(cin), .sum(sum), .cout(cout)
   );

   mm_shifter #(.D(D)) u_shf (.mode(sh_mode), .din(sum), .dout(shd));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         q_q   <= '0;
         u_q   <= '0;
         v_q   <= '0;
         p_q   <= '0;
      end else begin
         if (clr)         acc_q <= '0;
         else if (acc_we) acc_q <= shd;
         if (clr)          q_q <= '0;
         else if (q_shift) q_q <= {acc_q[0], q_q[W-1:1]};
         if (res_we)              u_q <= cout ? sum[W-1:0] : acc_q[W-1:0];
         else if (u_we && !busy)  u_q <= wdata;
         if (v_we && !busy) v_q <= wdata;
         if (p_we && !busy) p_q <= wdata;
      end
   end

   assign u_out = u_q;
   assign q_out = q_q;
endmodule

// File: rtl/mm_chk.sv
module mm_chk #(
   parameter int W = 1024
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         busy,
   input logic         done,
   input logic [W-1:0] u_out,
   input logic [W-1:0] q_out,
   input logic [W-1:0] p_q
);
   logic [31:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_cnt <= '0;
      else if (busy) run_cnt <= run_cnt + 1'b1;
      else           run_cnt <= '0;
   end

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R4
   done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   // R4
   run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_cnt == 32'(2 * W + 1)));
   // R5
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   // R1
   result_below_p_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (u_out < p_q));
   // R6
   u_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(u_out));
   // R3
   q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> $stable(q_out));
endmodule

bind mont_serial_mul mm_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .u_out(u_out), .q_out(q_out), .p_q(p_q)
);

// File: tb/sim_mont_serial_mul.sv
`timescale 1ns/1ps
module sim_mont_serial_mul;
   localparam int W = 64;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0, square = 1'b0;
   logic         u_we = 1'b0, v_we = 1'b0, p_we = 1'b0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] u_out, q_out;
   logic         busy, done;

   always #2 clk = ~clk;

   mont_serial_mul #(.W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .square(square),
      .u_we(u_we), .v_we(v_we), .p_we(p_we), .wdata(wdata),
      .u_out(u_out), .q_out(q_out), .busy(busy), .done(done)
   );

   typedef struct {
      logic [W-1:0] r, a, b, p;
      bit           sq;
   } exp_t;
   exp_t sbq[$];

   int checks = 0, fails = 0, nsub = 0, nnosub = 0;
   logic [W-1:0] mu, mv, mp;

   task automatic chk(input bit ok, input string req,
                      input logic [191:0] act, input logic [191:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] mref(input logic [W-1:0] a, b, p);
      logic [191:0] x;
      x = (192'(a) * 192'(b)) % 192'(p);
      for (int i = 0; i < W; i++) x = x[0] ? (x + 192'(p)) >> 1 : x >> 1;
      return x[W-1:0];
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sbq.size() == 0) chk(1'b0, "R1 unexpected done", 192'(u_out), 0);
         else begin
            exp_t e;
            logic [191:0] full, t;
            e = sbq.pop_front();
            chk(u_out == e.r, e.sq ? "R2 square result" : "R1 product", 192'(u_out), 192'(e.r));
            full = 192'(e.a) * 192'(e.b) + 192'(q_out) * 192'(e.p);
            t = full >> W;
            chk(full[W-1:0] == '0 && (t == 192'(e.r) || t == 192'(e.r) + 192'(e.p)),
                "R3 quotient", full, 192'(e.r));
            if (t != 192'(e.r)) nsub++; else nnosub++;
         end
      end
   end

   task automatic wr(input int sel, input logic [W-1:0] d);
      wdata = d;
      u_we = (sel == 0); v_we = (sel == 1); p_we = (sel == 2);
      @(posedge clk); @(negedge clk);
      u_we = 0; v_we = 0; p_we = 0;
      if (sel == 0) mu = d; else if (sel == 1) mv = d; else mp = d;
   endtask

   task automatic run_op(input bit sq, input bit disturb);
      exp_t e;
      int lat;
      e.a = mu; e.b = sq ? mu : mv; e.p = mp; e.sq = sq;
      e.r = mref(e.a, e.b, e.p);
      sbq.push_back(e);
      square = sq; start = 1;
      @(posedge clk); @(negedge clk);
      start = 0; square = 0;
      chk(busy == 1'b1, "R4 busy after start", 192'(busy), 1);
      lat = 0;
      while (!done && lat < 1000) begin
         @(posedge clk); @(negedge clk);
         lat++;
         if (disturb) begin
            start = (lat == 5);
            u_we = (lat == 5); v_we = (lat == 6); p_we = (lat == 7);
            wdata = '1;
         end
      end
      start = 0; u_we = 0; v_we = 0; p_we = 0;
      chk(lat == 2 * W + 1, disturb ? "R5 latency with stray start" : "R4 latency",
          192'(lat), 192'(2 * W + 1));
      @(posedge clk); @(negedge clk);
      chk(done == 1'b0, "R4 done single pulse", 192'(done), 0);
      chk(busy == 1'b0, "R5 no restart from ignored start", 192'(busy), 0);
      mu = e.r;
   endtask

   initial begin
      #(4 * 150000);
      chk(1'b0, "watchdog expired", 0, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [W-1:0] p0;
      repeat (3) @(negedge clk);
      // R7 reset state
      chk(busy == 0 && done == 0, "R7 reset flags", {busy, done}, 0);
      chk(u_out == 0 && q_out == 0, "R7 reset registers", {u_out, q_out}, 0);
      rst_n = 1;
      @(negedge clk);

      p0 = 64'hF1E2_D3C4_B5A6_9781;
      wr(2, p0);
      wr(0, 64'h1234_5678_9ABC_DEF0);
      wr(1, 64'h0FED_CBA9_8765_4321);
      run_op(0, 0);                     // R1
      wr(1, 64'h7777_0000_3333_1111);
      run_op(0, 0);                     // R8 chained on result
      run_op(1, 0);                     // R2 square
      wr(0, '0);
      run_op(0, 0);                     // R1 zero operand
      chk(u_out == 0 && q_out == 0, "R1 zero gives zero", {u_out, q_out}, 0);
      wr(0, p0 - 1); wr(1, p0 - 1);
      run_op(0, 0);                     // R9 boundary operands
      run_op(0, 1);                     // R5 R6 traffic while busy
      run_op(0, 0);                     // R6 old v and p still used
      wr(2, 64'd3); wr(0, 64'd2); wr(1, 64'd2);
      run_op(0, 0);                     // R1 tiny modulus
      for (int k = 0; k < 20; k++) begin
         logic [W-1:0] p;
         p = {$urandom, $urandom} | 64'd1;
         if (k % 4 == 0) p = p | 64'h8000_0000_0000_0000;
         wr(2, p);
         wr(0, {$urandom, $urandom} % p);
         wr(1, {$urandom, $urandom} % p);
         run_op(k % 3 == 2, 0);
      end
      chk(sbq.size() == 0, "R1 every product reported", 192'(sbq.size()), 0);
      chk(nsub > 0, "R9 correction taken", 192'(nsub), 1);
      chk(nnosub > 0, "R9 correction skipped", 192'(nnosub), 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule